// File: doc/BRIEF.md
# Paged Channel Register Command Interface

This block is the host-side register front end of an eight-channel serial controller. The host sees one small address map. A selector register at offset 0 names the channel that every later channel-register access reaches, so the same offsets serve all eight channels and the host never works out per-channel addresses. Each channel holds three option registers, three active-configuration shadows, a command register and a status register.

The host changes a channel's options and then posts a command word. The word can flag which option registers changed and can ask for the transmitter to be switched on or off. An internal sequencer visits one channel per clock in a fixed rotation. When it finds a nonzero command, it carries out every flagged action in that single visit and then zeroes the command. The zero value is the completion signal that the host polls for. A host write to a command register that is still busy is dropped and raises a per-channel sticky error bit.

Top module: `chanreg_top`

## Requirements
- R1: After reset, every readable location of every channel reads 0: the selector, the options, the active shadows, the command and the status.
- R2: A write to offset 0 stores the low three data bits as the selected channel, and reading offset 0 returns that value. The selected channel decides which channel's registers offsets 1 to 8 reach.
- R3: Offsets 1, 2 and 3 reach option registers 1 to 3 of the selected channel only. The other channels' options stay unchanged.
- R4: The sequencer visits channels 0, 1, …, 7 and then 0 again, one channel per clock, starting at channel 0 when reset is released.
- R5: A write to offset 4 stores only command bits 1 to 5. Bits 0, 6 and 7 are reserved and dropped, so a word with only reserved bits leaves the register at 0 and starts no work. Reading offset 4 returns the stored command.
- R6: When the sequencer visits a channel whose command is nonzero, each set bit k (k = 1 to 3) copies option register k into active shadow k. Active shadows 1 to 3 read at offsets 5, 6 and 7. The command is zeroed in the same clock.
- R7: Command bit 4 enables the channel's transmitter and bit 5 disables it. When both bits are set, the transmitter ends up disabled. Status (offset 8) bit 0 shows the transmitter enable and bit 1 shows the sticky error.
- R8: A command write to a channel whose command is still nonzero (value before the clock edge) is ignored and sets that channel's error bit. The error bit stays set until reset.
- R9: Reads are registered: read data takes the addressed value one clock after the read strobe and holds it while no read is strobed. Offsets 9 to 15 read 0, and writes to them change nothing.
- R10: A posted command is still visible for at least one clock after its write and is zeroed within eight clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 4 | Register offset |
| hostWrEn | input | 1 | Write strobe |
| hostWrData | input | 8 | Write data |
| hostRdEn | input | 1 | Read strobe |
| hostRdData | output | 8 | Registered read data |

## Verification
The assertions check on every cycle that the sequencer advances by exactly one channel and wraps. They also check that a nonzero command seen by the sequencer is gone on the next cycle, that command bits and transmit enables change only for the channel being visited, and that error bits never fall. Whether the right option reaches the right shadow, how reserved bits are masked, that disable wins over enable, the width of the busy window, and that selector paging keeps channels apart can only be shown by the bench's scenarios. There, a behavioural model predicts the read data on every clock.

// File: rtl/chanreg_pkg.sv
`timescale 1ns/1ps
package chanreg_pkg;
  parameter int NumCh  = 8;
  parameter int ChW    = $clog2(NumCh);
  parameter int DataW  = 8;
  parameter int AddrW  = 4;
  parameter int NumOpt = 3;

  // Offset map
  parameter int OffSel  = 0;
  parameter int OffOpt0 = 1;
  parameter int OffCmd  = OffOpt0 + NumOpt;
  parameter int OffAct0 = OffCmd + 1;
  parameter int OffStat = OffAct0 + NumOpt;

  // Command bit positions
  parameter int CmdOptLo = 1;
  parameter int CmdTxEn  = CmdOptLo + NumOpt;
  parameter int CmdTxDis = CmdTxEn + 1;
  parameter logic [DataW-1:0] CmdMask =
      DataW'(((1 << (CmdTxDis + 1)) - 1) & ~((1 << CmdOptLo) - 1));

  typedef struct packed {
    logic              selWr;
    logic [NumOpt-1:0] optWr;
    logic              cmdWr;
    logic              svc;
    logic [ChW-1:0]    svcCh;
  } ctlStrobe_t;
endpackage

// File: rtl/chanreg_ctrl.sv
`timescale 1ns/1ps
module chanreg_ctrl
  import chanreg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [AddrW-1:0] hostAddr,
  input  logic             hostWrEn,
  input  logic [NumCh-1:0] cmdPending,
  output logic [ChW-1:0]   scanPtr,
  output ctlStrobe_t       strb
);
  localparam logic [ChW-1:0] LastCh = ChW'(NumCh - 1);

  // Round-robin visit pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) scanPtr <= '0;
    else if (scanPtr == LastCh) scanPtr <= '0;
    else scanPtr <= scanPtr + 1'b1;
  end

  // Host write decode
  assign strb.selWr = hostWrEn && (hostAddr == AddrW'(OffSel));
  assign strb.cmdWr = hostWrEn && (hostAddr == AddrW'(OffCmd));

  for (genvar k = 0; k < NumOpt; k++) begin : g_optDec
    assign strb.optWr[k] = hostWrEn && (hostAddr == AddrW'(OffOpt0 + k));
  end

  // Service strobe for the visited channel
  assign strb.svc   = cmdPending[scanPtr];
  assign strb.svcCh = scanPtr;
endmodule

// File: rtl/chanreg_data.sv
`timescale 1ns/1ps
module chanreg_data
  import chanreg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strb,
  input  logic [AddrW-1:0] hostAddr,
  input  logic [DataW-1:0] hostWrData,
  input  logic             hostRdEn,
  output logic [DataW-1:0] hostRdData,
  output logic [NumCh-1:0] cmdPending,
  output logic [NumCh-1:0] txEnVec,
  output logic [NumCh-1:0] errVec
);
  logic [ChW-1:0]   chanSel;
  logic [DataW-1:0] optReg [NumCh][NumOpt];
  logic [DataW-1:0] actReg [NumCh][NumOpt];
  logic [DataW-1:0] cmdReg [NumCh];
  logic [DataW-1:0] rdNext;
  logic [DataW-1:0] rdReg;

  always_comb begin
    for (int c = 0; c < NumCh; c++) cmdPending[c] = |cmdReg[c];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanSel <= '0;
      rdReg   <= '0;
      txEnVec <= '0;
      errVec  <= '0;
      for (int c = 0; c < NumCh; c++) begin
        cmdReg[c] <= '0;
        for (int k = 0; k < NumOpt; k++) begin
          optReg[c][k] <= '0;
          actReg[c][k] <= '0;
        end
      end
    end else begin
      if (hostRdEn) rdReg <= rdNext;
      if (strb.selWr) chanSel <= hostWrData[ChW-1:0];
      for (int c = 0; c < NumCh; c++) begin
        // host side
        for (int k = 0; k < NumOpt; k++)
          if (strb.optWr[k] && chanSel == ChW'(c)) optReg[c][k] <= hostWrData;
        if (strb.cmdWr && chanSel == ChW'(c)) begin
          if (cmdReg[c] == '0) cmdReg[c] <= hostWrData & CmdMask;
          else errVec[c] <= 1'b1;
        end
        // sequencer side (only ever when command nonzero)
        if (strb.svc && strb.svcCh == ChW'(c)) begin
          for (int k = 0; k < NumOpt; k++)
            if (cmdReg[c][CmdOptLo + k]) actReg[c][k] <= optReg[c][k];
          if (cmdReg[c][CmdTxDis]) txEnVec[c] <= 1'b0;
          else if (cmdReg[c][CmdTxEn]) txEnVec[c] <= 1'b1;
          cmdReg[c] <= '0;
        end
      end
    end
  end

  // Read mux over the selected channel
  always_comb begin
    rdNext = '0;
    if (hostAddr == AddrW'(OffSel)) rdNext = DataW'(chanSel);
    for (int k = 0; k < NumOpt; k++) begin
      if (hostAddr == AddrW'(OffOpt0 + k)) rdNext = optReg[chanSel][k];
      if (hostAddr == AddrW'(OffAct0 + k)) rdNext = actReg[chanSel][k];
    end
    if (hostAddr == AddrW'(OffCmd)) rdNext = cmdReg[chanSel];
    if (hostAddr == AddrW'(OffStat))
      rdNext = {{(DataW-2){1'b0}}, errVec[chanSel], txEnVec[chanSel]};
  end

  assign hostRdData = rdReg;
endmodule

// File: rtl/chanreg_top.sv
`timescale 1ns/1ps
module chanreg_top
  import chanreg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [AddrW-1:0] hostAddr,
  input  logic             hostWrEn,
  input  logic [DataW-1:0] hostWrData,
  input  logic             hostRdEn,
  output logic [DataW-1:0] hostRdData
);
  ctlStrobe_t       strb;
  logic [ChW-1:0]   scanPtr;
  logic [NumCh-1:0] cmdPending;
  logic [NumCh-1:0] txEnVec;
  logic [NumCh-1:0] errVec;

  chanreg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .cmdPending(cmdPending), .scanPtr(scanPtr), .strb(strb)
  );

  chanreg_data u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdEn(hostRdEn), .hostRdData(hostRdData),
    .cmdPending(cmdPending), .txEnVec(txEnVec), .errVec(errVec)
  );
endmodule

// File: rtl/chanreg_chk.sv
`timescale 1ns/1ps
module chanreg_chk
  import chanreg_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [ChW-1:0]   scanPtr,
  input logic [NumCh-1:0] cmdPending,
  input logic [NumCh-1:0] txEnVec,
  input logic [NumCh-1:0] errVec
);
  logic [NumCh-1:0] ptrOh;
  assign ptrOh = {{(NumCh-1){1'b0}}, 1'b1} << scanPtr;

  a_r4_scan_step: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> scanPtr == (($past(scanPtr) == ChW'(NumCh-1)) ? '0 : $past(scanPtr) + 1'b1));

  a_r6_clear_on_visit: assert property (@(posedge clk) disable iff (!rstN)
    cmdPending[scanPtr] |=> !cmdPending[$past(scanPtr)]);

  a_r10_clear_only_at_visit: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(cmdPending) & ~cmdPending & ~$past(ptrOh)) == '0));

  a_r7_txen_only_at_visit: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((txEnVec ^ $past(txEnVec)) & ~$past(ptrOh)) == '0));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((errVec & $past(errVec)) == $past(errVec)));
endmodule

bind chanreg_top chanreg_chk u_chk (
  .clk(clk), .rstN(rstN), .scanPtr(scanPtr), .cmdPending(cmdPending),
  .txEnVec(txEnVec), .errVec(errVec)
);

// File: tb/sim_chanreg_top.sv
`timescale 1ns/1ps
module sim_chanreg_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] hostAddr = '0;
  logic       hostWrEn = 1'b0;
  logic [7:0] hostWrData = '0;
  logic       hostRdEn = 1'b0;
  logic [7:0] hostRdData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  chanreg_top u0 (.*);

  always #2.5 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int mSel, mPtr, mRd;
  int mOpt[8][3], mAct[8][3], mCmd[8], mTx[8], mErr[8];

  function automatic int readVal(int a);
    if (a == 0) return mSel;
    if (a >= 1 && a <= 3) return mOpt[mSel][a-1];
    if (a == 4) return mCmd[mSel];
    if (a >= 5 && a <= 7) return mAct[mSel][a-5];
    if (a == 8) return mErr[mSel] * 2 + mTx[mSel];
    return 0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSel = 0; mPtr = 0; mRd = 0;
      for (int c = 0; c < 8; c++) begin
        mCmd[c] = 0; mTx[c] = 0; mErr[c] = 0;
        for (int k = 0; k < 3; k++) begin mOpt[c][k] = 0; mAct[c][k] = 0; end
      end
    end else begin
      int preSel, preBusy, sc;
      preSel = mSel;
      preBusy = (mCmd[preSel] != 0);
      if (hostRdEn) mRd = readVal(int'(hostAddr));
      sc = mPtr;
      if (mCmd[sc] != 0) begin
        for (int k = 0; k < 3; k++)
          if ((mCmd[sc] >> (k+1)) & 1) mAct[sc][k] = mOpt[sc][k];
        if ((mCmd[sc] >> 5) & 1) mTx[sc] = 0;
        else if ((mCmd[sc] >> 4) & 1) mTx[sc] = 1;
        mCmd[sc] = 0;
      end
      mPtr = (mPtr + 1) % 8;
      if (hostWrEn) begin
        if (hostAddr == 0) mSel = int'(hostWrData) % 8;
        if (hostAddr >= 1 && hostAddr <= 3) mOpt[preSel][hostAddr-1] = int'(hostWrData);
        if (hostAddr == 4) begin
          if (preBusy) mErr[preSel] = 1;
          else mCmd[preSel] = int'(hostWrData) & 8'h3E;
        end
      end
    end
  end

  // Per-cycle comparison of read data (R4, R6, R9 timing)
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (int'(hostRdData) != mRd) begin
        errors++;
        $display("FAIL R9 per-cycle rdData actual=%0h expected=%0h", hostRdData, mRd);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); hostAddr = 4'(a); hostWrData = 8'(d); hostWrEn = 1'b1;
    @(negedge clk); hostWrEn = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk); hostAddr = 4'(a); hostRdEn = 1'b1;
    @(negedge clk); hostRdEn = 1'b0; v = int'(hostRdData);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Watchdog
  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  // ---------------- scenarios ----------------
  initial begin
    int v, polls;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state of channel 0
    for (int a = 0; a < 9; a++) begin rd(a, v); chk($sformatf("R1 reset offset %0d", a), v, 0); end
    // R9: unmapped offset reads 0, writes ignored
    wr(12, 8'h5A);
    rd(12, v); chk("R9 unmapped read", v, 0);
    rd(1, v);  chk("R9 unmapped write no effect", v, 0);

    // R2/R3: paged option writes
    for (int c = 0; c < 8; c++) begin
      wr(0, c);
      for (int k = 0; k < 3; k++) wr(1 + k, c * 16 + k + 1);
    end
    for (int c = 7; c >= 0; c--) begin
      wr(0, c);
      rd(0, v); chk("R2 selector readback", v, c);
      for (int k = 0; k < 3; k++) begin
        rd(1 + k, v); chk($sformatf("R3 ch%0d opt%0d", c, k + 1), v, c * 16 + k + 1);
      end
    end
    wr(0, 8'hFA);
    rd(0, v); chk("R2 low bits only", v, 2);

    // R6: option-changed copy into active shadows
    wr(0, 3);
    rd(5, v); chk("R6 shadow before command", v, 0);
    wr(4, 8'h0E);
    idle(10);
    for (int k = 0; k < 3; k++) begin
      rd(5 + k, v); chk($sformatf("R6 active%0d", k + 1), v, 3 * 16 + k + 1);
    end
    rd(4, v); chk("R6 command cleared", v, 0);
    // partial copy: only option 2 on channel 4
    wr(0, 4); wr(2, 8'hAB); wr(3, 8'hCD); wr(4, 8'h04);
    idle(10);
    rd(6, v); chk("R6 partial flagged", v, 8'hAB);
    rd(7, v); chk("R6 partial unflagged", v, 0);

    // R5: reserved-only command
    wr(0, 5);
    wr(4, 8'hC1);
    rd(4, v); chk("R5 reserved dropped", v, 0);
    rd(8, v); chk("R5 no error from reserved", v, 0);

    // R7: enable, disable, both
    wr(4, 8'h10); idle(10);
    rd(8, v); chk("R7 enabled", v, 1);
    wr(4, 8'h30); idle(10);
    rd(8, v); chk("R7 both bits disable", v, 0);
    wr(4, 8'h10); idle(10);
    wr(4, 8'h20); idle(10);
    rd(8, v); chk("R7 disabled", v, 0);

    // R8: busy write ignored, sticky error
    wr(0, 6);
    @(negedge clk); hostAddr = 4; hostWrData = 8'h10; hostWrEn = 1'b1;
    @(negedge clk); hostWrData = 8'h20;
    @(negedge clk); hostWrEn = 1'b0;
    idle(10);
    rd(8, v); chk("R8 busy write ignored and error set", v, 3);
    wr(4, 8'h20); idle(10);
    rd(8, v); chk("R8 error sticky after good command", v, 2);
    wr(0, 1);
    rd(8, v); chk("R8 error per channel", v, 0);

    // R10: busy window and completion bound
    wr(0, 7);
    wr(4, 8'h02);
    hostAddr = 4; hostRdEn = 1'b1;
    @(negedge clk);
    chk("R10 busy visible after write", int'(hostRdData), 2);
    polls = 1;
    while (hostRdData != 0 && polls < 20) begin @(negedge clk); polls++; end
    hostRdEn = 1'b0;
    checks++;
    if (polls > 9) begin
      errors++;
      $display("FAIL R10 completion polls actual=%0d expected<=9", polls);
    end
    rd(5, v); chk("R10 active after completion", v, 7 * 16 + 1);

    // R9: read data holds without strobe
    idle(5);
    chk("R9 hold", int'(hostRdData), 7 * 16 + 1);

    idle(3);
    finishRun();
  end
endmodule